// File: doc/BRIEF.md
# PHY Discovery and Autonegotiation Sequencer

This block brings up an Ethernet PHY over a management (MDIO) link without software help. After a start pulse it searches the 32 management addresses for a device that answers, resets the first one it finds, takes it out of isolation and programs it to advertise every 10/100 ability before it restarts autonegotiation. It then waits for the link to come up and captures the partner's ability word. It does not drive the MDIO pins. It issues one register transaction at a time to a separate MDIO master through a request/done handshake.

Negotiation polling is paced by an external tick, such as a millisecond strobe. Two run-time inputs set the number of ticks between polls and the number of polls allowed before the block gives up. When a run finishes, exactly one outcome flag is raised: success, no device found, device vanished, reset timeout or negotiation timeout. The flag holds until the next start. Working out speed and duplex from the captured words is left to the logic downstream.

Top module: `phy_an_seq`

## Requirements
- R1: Addresses are probed from 0 upward. Each probe reads register 0 (control) and then register 1 (status). An address counts as absent if either value is 16'hFFFF. The first address where neither read is 16'hFFFF is taken, and `phy_found` and `phy_addr` report it.
- R2: If address 2**ADDR_W-1 is also absent, `err_no_phy` is raised and the block goes idle. No write transaction is issued during the run.
- R3: Once a device is found, its control register is read again and written back with bit 15 (16'h8000) set. All other bits keep their read values.
- R4: After the reset write, register 0 is read back to back until bit 15 reads 0. If RST_POLL_MAX reads in a row have bit 15 set, `err_rst_timeout` is raised and the run stops.
- R5: If any reset poll returns 16'hFFFF, `err_vanished` is raised and the run stops immediately.
- R6: When bit 15 clears, register 0 is written with the last polled value with bit 10 (16'h0400) cleared.
- R7: Register 1 is then read twice in succession. The bitwise OR of the two reads is reported on `status_word`. The same OR rule applies to every negotiation poll.
- R8: Register 4 is written with 16'h01E1, and then register 0 is written with 16'h1200.
- R9: Each negotiation poll is one status read pair. Negotiation has succeeded when the ORed value has bit 2 (16'h0004) and bit 5 (16'h0020) set. Register 5 is then read, its value is shown on `partner_word`, and `an_done` is raised.
- R10: After a failed poll the block issues no request until `cfg_poll_ticks` tick pulses have been seen (1 or more). If `cfg_poll_max` polls fail, `err_an_timeout` is raised with no further wait.
- R11: A request stays asserted, with write flag, address, register and data unchanged, until the cycle in which `mdio_done` is high. No request is asserted while idle.
- R12: A start pulse while `busy` is high has no effect. A start while idle clears all outcome flags. Every run ends with exactly one of `an_done`, `err_no_phy`, `err_vanished`, `err_rst_timeout`, `err_an_timeout` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| tick | input | 1 | Pacing strobe for negotiation polls |
| cfg_poll_ticks | input | TICK_W | Ticks between negotiation polls |
| cfg_poll_max | input | POLL_W | Negotiation polls before timeout |
| req_valid | output | 1 | Management transaction requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | ADDR_W | Device address of the transaction |
| req_reg | output | 5 | Register number of the transaction |
| req_wdata | output | 16 | Write data |
| mdio_done | input | 1 | One-cycle completion from the MDIO master |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| busy | output | 1 | Run in progress |
| phy_found | output | 1 | A device was found in this run |
| phy_addr | output | ADDR_W | Address of the found device |
| an_done | output | 1 | Negotiation completed |
| err_no_phy | output | 1 | No address answered |
| err_vanished | output | 1 | Device read as all ones during reset polling |
| err_rst_timeout | output | 1 | Reset bit never cleared |
| err_an_timeout | output | 1 | Negotiation poll limit reached |
| status_word | output | 16 | ORed value of the latest status read pair |
| partner_word | output | 16 | Captured link partner ability word |

## Verification
The assertions check the handshake discipline on every cycle: held requests, no requests while idle, no write before a device is found, the fixed advertisement value, flags cleared on start, and exactly one outcome flag at the end of each run. The scan order, the reset and isolate values written, the OR of the status pairs, the tick spacing between polls and each abort path depend on what the device returns. Only the bench scenarios can show these. A model there predicts the full transaction sequence for each device configuration and counts the ticks in every poll gap.

// File: rtl/phy_an_pkg.sv
package phy_an_pkg;

   localparam int unsigned DATA_W = 16;
   localparam int unsigned REG_W  = 5;

   localparam logic [REG_W-1:0] REG_CTRL = 5'd0;
   localparam logic [REG_W-1:0] REG_STAT = 5'd1;
   localparam logic [REG_W-1:0] REG_ADV  = 5'd4;
   localparam logic [REG_W-1:0] REG_LPA  = 5'd5;

   localparam logic [DATA_W-1:0] ALL_ONES    = 16'hFFFF;
   localparam logic [DATA_W-1:0] CTRL_RESET  = 16'h8000;
   localparam logic [DATA_W-1:0] CTRL_ISO    = 16'h0400;
   localparam logic [DATA_W-1:0] ADV_ALL     = 16'h01E1;
   localparam logic [DATA_W-1:0] AN_RESTART  = 16'h1200;
   localparam logic [DATA_W-1:0] STAT_LINK   = 16'h0004;
   localparam logic [DATA_W-1:0] STAT_ANDONE = 16'h0020;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SCAN_CTL,
      ST_SCAN_STS,
      ST_GET_CTL,
      ST_RST_WR,
      ST_RST_POLL,
      ST_ISO_WR,
      ST_STS_A,
      ST_STS_B,
      ST_ADV_WR,
      ST_AN_WR,
      ST_NEG_A,
      ST_NEG_B,
      ST_NEG_WAIT,
      ST_LPA_RD
   } seq_state_e;

   typedef struct packed {
      logic                 valid;
      logic                 write;
      logic [REG_W-1:0]     regno;
      logic [DATA_W-1:0]    wdata;
   } mgmt_req_t;

endpackage

// File: rtl/phy_an_pacer.sv
module phy_an_pacer #(
   parameter int unsigned TICK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [TICK_W-1:0] cfg_ticks,
   output logic              expire
);

   logic [TICK_W-1:0] seen_q;

   // leave on the edge that delivers the last required tick
   always_comb begin
      expire = 1'b0;
      if (run) begin
         if (cfg_ticks == '0)
            expire = 1'b1;
         else if (tick && (seen_q == cfg_ticks - 1'b1))
            expire = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_q <= '0;
      else if (!run || expire)
         seen_q <= '0;
      else if (tick)
         seen_q <= seen_q + 1'b1;
   end

endmodule

// File: rtl/phy_an_bound.sv
module phy_an_bound #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         last
);

   logic [W-1:0] used_q;

   // the attempt in progress is the final one allowed
   assign last = ({1'b0, used_q} + 1'b1) >= {1'b0, limit};

   always_ff @(posedge clk) begin
      if (!rst_n)
         used_q <= '0;
      else if (clr)
         used_q <= '0;
      else if (inc && !last)
         used_q <= used_q + 1'b1;
   end

endmodule

// File: rtl/phy_an_seq.sv
module phy_an_seq
   import phy_an_pkg::*;
#(
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned TICK_W       = 8,
   parameter int unsigned POLL_W       = 8,
   parameter int unsigned RST_POLL_MAX = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic [TICK_W-1:0] cfg_poll_ticks,
   input  logic [POLL_W-1:0] cfg_poll_max,
   output logic              req_valid,
   output logic              req_write,
   output logic [ADDR_W-1:0] req_phy,
   output logic [4:0]        req_reg,
   output logic [15:0]       req_wdata,
   input  logic              mdio_done,
   input  logic [15:0]       mdio_rdata,
   output logic              busy,
   output logic              phy_found,
   output logic [ADDR_W-1:0] phy_addr,
   output logic              an_done,
   output logic              err_no_phy,
   output logic              err_vanished,
   output logic              err_rst_timeout,
   output logic              err_an_timeout,
   output logic [15:0]       status_word,
   output logic [15:0]       partner_word
);

   localparam int unsigned        RST_W     = $clog2(RST_POLL_MAX + 1);
   localparam logic [ADDR_W-1:0]  LAST_ADDR = {ADDR_W{1'b1}};
   localparam logic [RST_W-1:0]   RST_LIMIT = RST_W'(RST_POLL_MAX);

   if (ADDR_W < 1 || ADDR_W > 5) begin : g_bad_addr
      $error("phy_an_seq: ADDR_W must be 1..5");
   end
   if (TICK_W < 1) begin : g_bad_tick
      $error("phy_an_seq: TICK_W must be at least 1");
   end
   if (POLL_W < 1) begin : g_bad_poll
      $error("phy_an_seq: POLL_W must be at least 1");
   end
   if (RST_POLL_MAX < 1) begin : g_bad_rst
      $error("phy_an_seq: RST_POLL_MAX must be at least 1");
   end

   seq_state_e          state_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [15:0]         ctl_q;
   logic [15:0]         first_q;
   logic [15:0]         status_q;
   logic [15:0]         partner_q;
   logic                found_q;
   logic                ok_q, nophy_q, gone_q, rsto_q, anto_q;
   mgmt_req_t           req;

   logic                rst_last, neg_last, wait_over;
   logic                rst_inc, neg_inc;
   logic [15:0]         pair_or;
   logic                absent;

   assign pair_or = first_q | mdio_rdata;
   assign absent  = (ctl_q == ALL_ONES) || (mdio_rdata == ALL_ONES);
   assign rst_inc = (state_q == ST_RST_POLL) && mdio_done;
   assign neg_inc = (state_q == ST_NEG_B) && mdio_done;

   phy_an_bound #(.W(RST_W)) u_rst_bound (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q != ST_RST_POLL),
      .inc   (rst_inc),
      .limit (RST_LIMIT),
      .last  (rst_last)
   );

   phy_an_bound #(.W(POLL_W)) u_neg_bound (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == ST_AN_WR),
      .inc   (neg_inc),
      .limit (cfg_poll_max),
      .last  (neg_last)
   );

   phy_an_pacer #(.TICK_W(TICK_W)) u_pacer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (state_q == ST_NEG_WAIT),
      .tick      (tick),
      .cfg_ticks (cfg_poll_ticks),
      .expire    (wait_over)
   );

   // request decode from the current step
   always_comb begin
      req = '0;
      unique case (state_q)
         ST_SCAN_CTL, ST_GET_CTL, ST_RST_POLL: begin
            req.valid = 1'b1;
            req.regno = REG_CTRL;
         end
         ST_SCAN_STS, ST_STS_A, ST_STS_B, ST_NEG_A, ST_NEG_B: begin
            req.valid = 1'b1;
            req.regno = REG_STAT;
         end
         ST_RST_WR: begin
            req.valid = 1'b1;
            req.write = 1'b1;
            req.regno = REG_CTRL;
            req.wdata = ctl_q | CTRL_RESET;
         end
         ST_ISO_WR: begin
            req.valid = 1'b1;
            req.write = 1'b1;
            req.regno = REG_CTRL;
            req.wdata = ctl_q & ~CTRL_ISO;
         end
         ST_ADV_WR: begin
            req.valid = 1'b1;
            req.write = 1'b1;
            req.regno = REG_ADV;
            req.wdata = ADV_ALL;
         end
         ST_AN_WR: begin
            req.valid = 1'b1;
            req.write = 1'b1;
            req.regno = REG_CTRL;
            req.wdata = AN_RESTART;
         end
         ST_LPA_RD: begin
            req.valid = 1'b1;
            req.regno = REG_LPA;
         end
         default: req = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         ctl_q     <= '0;
         first_q   <= '0;
         status_q  <= '0;
         partner_q <= '0;
         found_q   <= 1'b0;
         ok_q      <= 1'b0;
         nophy_q   <= 1'b0;
         gone_q    <= 1'b0;
         rsto_q    <= 1'b0;
         anto_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q    <= '0;
                  found_q   <= 1'b0;
                  status_q  <= '0;
                  partner_q <= '0;
                  ok_q      <= 1'b0;
                  nophy_q   <= 1'b0;
                  gone_q    <= 1'b0;
                  rsto_q    <= 1'b0;
                  anto_q    <= 1'b0;
                  state_q   <= ST_SCAN_CTL;
               end
            end
            ST_SCAN_CTL: if (mdio_done) begin
               ctl_q   <= mdio_rdata;
               state_q <= ST_SCAN_STS;
            end
            ST_SCAN_STS: if (mdio_done) begin
               if (!absent) begin
                  found_q <= 1'b1;
                  state_q <= ST_GET_CTL;
               end else if (addr_q == LAST_ADDR) begin
                  nophy_q <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  addr_q  <= addr_q + 1'b1;
                  state_q <= ST_SCAN_CTL;
               end
            end
            ST_GET_CTL: if (mdio_done) begin
               ctl_q   <= mdio_rdata;
               state_q <= ST_RST_WR;
            end
            ST_RST_WR: if (mdio_done) begin
               state_q <= ST_RST_POLL;
            end
            ST_RST_POLL: if (mdio_done) begin
               if (mdio_rdata == ALL_ONES) begin
                  gone_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if ((mdio_rdata & CTRL_RESET) == '0) begin
                  ctl_q   <= mdio_rdata;
                  state_q <= ST_ISO_WR;
               end else if (rst_last) begin
                  rsto_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_ISO_WR: if (mdio_done) begin
               state_q <= ST_STS_A;
            end
            ST_STS_A: if (mdio_done) begin
               first_q <= mdio_rdata;
               state_q <= ST_STS_B;
            end
            ST_STS_B: if (mdio_done) begin
               status_q <= pair_or;
               state_q  <= ST_ADV_WR;
            end
            ST_ADV_WR: if (mdio_done) begin
               state_q <= ST_AN_WR;
            end
            ST_AN_WR: if (mdio_done) begin
               state_q <= ST_NEG_A;
            end
            ST_NEG_A: if (mdio_done) begin
               first_q <= mdio_rdata;
               state_q <= ST_NEG_B;
            end
            ST_NEG_B: if (mdio_done) begin
               status_q <= pair_or;
               if (((pair_or & STAT_LINK) != '0) && ((pair_or & STAT_ANDONE) != '0))
                  state_q <= ST_LPA_RD;
               else if (neg_last) begin
                  anto_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else
                  state_q <= ST_NEG_WAIT;
            end
            ST_NEG_WAIT: if (wait_over) begin
               state_q <= ST_NEG_A;
            end
            ST_LPA_RD: if (mdio_done) begin
               partner_q <= mdio_rdata;
               ok_q      <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid       = req.valid;
   assign req_write       = req.write;
   assign req_phy         = addr_q;
   assign req_reg         = req.regno;
   assign req_wdata       = req.wdata;
   assign busy            = (state_q != ST_IDLE);
   assign phy_found       = found_q;
   assign phy_addr        = addr_q;
   assign an_done         = ok_q;
   assign err_no_phy      = nophy_q;
   assign err_vanished    = gone_q;
   assign err_rst_timeout = rsto_q;
   assign err_an_timeout  = anto_q;
   assign status_word     = status_q;
   assign partner_word    = partner_q;

endmodule

// File: rtl/phy_an_seq_chk.sv
module phy_an_seq_chk #(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_phy,
   input logic [4:0]        req_reg,
   input logic [15:0]       req_wdata,
   input logic              mdio_done,
   input logic              busy,
   input logic              phy_found,
   input logic              an_done,
   input logic              err_no_phy,
   input logic              err_vanished,
   input logic              err_rst_timeout,
   input logic              err_an_timeout
);

   logic [4:0] outcome;
   assign outcome = {an_done, err_no_phy, err_vanished, err_rst_timeout, err_an_timeout};

   // R11: an outstanding request is held unchanged until completion
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mdio_done) |=> (req_valid && $stable(req_write) && $stable(req_phy)
                                     && $stable(req_reg) && $stable(req_wdata)));

   // R11: nothing is requested while idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);

   // R2: writes only ever go to a device that was found
   p_write_found_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |-> phy_found);

   // R8: the advertisement register only receives the full ability word
   p_adv_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_reg == 5'd4) |-> (req_wdata == 16'h01E1));

   // R12: a start while idle launches a run with all outcomes cleared
   p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && outcome == 5'b0));

   // R12: each run ends with exactly one outcome
   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($countones(outcome) == 1));

   // R12: never more than one outcome at a time
   p_outcome_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(outcome));

endmodule

bind phy_an_seq phy_an_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_phy_an_seq.sv
module tb_phy_an_seq;

   localparam int LAT     = 2;
   localparam int RST_MAX = 100;
   localparam logic [15:0] CTL_DEF = 16'h3400;
   localparam logic [15:0] STS_DEF = 16'h7809;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        tick = 1'b0;
   logic [7:0]  cfg_poll_ticks = 8'd2;
   logic [7:0]  cfg_poll_max = 8'd8;
   logic        req_valid, req_write;
   logic [4:0]  req_phy, req_reg;
   logic [15:0] req_wdata;
   logic        mdio_done = 1'b0;
   logic [15:0] mdio_rdata = 16'h0;
   logic        busy, phy_found, an_done, err_no_phy, err_vanished;
   logic        err_rst_timeout, err_an_timeout;
   logic [4:0]  phy_addr;
   logic [15:0] status_word, partner_word;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   phy_an_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .cfg_poll_ticks(cfg_poll_ticks), .cfg_poll_max(cfg_poll_max),
      .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
      .req_reg(req_reg), .req_wdata(req_wdata),
      .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
      .busy(busy), .phy_found(phy_found), .phy_addr(phy_addr),
      .an_done(an_done), .err_no_phy(err_no_phy), .err_vanished(err_vanished),
      .err_rst_timeout(err_rst_timeout), .err_an_timeout(err_an_timeout),
      .status_word(status_word), .partner_word(partner_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   int          m_addr, m_half, m_rst_reads, m_vanish, m_an_after;
   logic [15:0] m_lpa, m_ctl;
   bit          m_rst_on, m_an_on;
   int          m_rst_left, m_poll, m_sts_reads;

   task automatic dev_access(input logic w, input logic [4:0] a, input logic [4:0] r,
                             input logic [15:0] wd, output logic [15:0] rd);
      rd = 16'hFFFF;
      if (int'(a) == m_half && m_half != m_addr) begin
         rd = (r == 5'd0) ? 16'h1000 : 16'hFFFF;
      end else if (int'(a) == m_addr) begin
         if (w) begin
            if (r == 5'd0) begin
               if (wd[15]) begin
                  m_rst_on = 1; m_rst_left = m_rst_reads; m_poll = 0; m_ctl = CTL_DEF;
               end else if (wd == 16'h1200) begin
                  m_an_on = 1; m_sts_reads = 0; m_ctl = wd; m_rst_on = 0;
               end else begin
                  m_ctl = wd; m_rst_on = 0;
               end
            end
         end else begin
            case (r)
               5'd0: begin
                  if (m_rst_on) begin
                     if (m_poll == m_vanish) rd = 16'hFFFF;
                     else if (m_rst_left > 0) begin rd = m_ctl | 16'h8000; m_rst_left--; end
                     else rd = m_ctl;
                     m_poll++;
                  end else rd = m_ctl;
               end
               5'd1: begin
                  rd = STS_DEF;
                  if (m_an_on) begin
                     if (m_sts_reads / 2 >= m_an_after)
                        rd = (m_sts_reads % 2 == 1) ? (STS_DEF | 16'h0004) : (STS_DEF | 16'h0020);
                     m_sts_reads++;
                  end
               end
               5'd5: rd = m_lpa;
               default: rd = 16'h0000;
            endcase
         end
      end
   endtask

   // MDIO master stand-in: fixed latency, one transaction at a time
   int rsp_cnt = 0;
   bit rsp_act = 0;
   always @(posedge clk) begin
      logic [15:0] rd;
      if (!rst_n) begin
         rsp_act <= 0; mdio_done <= 1'b0;
      end else begin
         mdio_done <= 1'b0;
         if (rsp_act) begin
            if (rsp_cnt == 0) begin
               dev_access(req_write, req_phy, req_reg, req_wdata, rd);
               mdio_done  <= 1'b1;
               mdio_rdata <= rd;
               rsp_act    <= 0;
            end else rsp_cnt <= rsp_cnt - 1;
         end else if (req_valid && !mdio_done) begin
            rsp_act <= 1; rsp_cnt <= LAT;
         end
      end
   end

   // tick strobe every fourth cycle, changed just after the edge
   initial begin
      int n = 0;
      forever begin
         @(posedge clk); #1;
         tick = (n % 4 == 0);
         n++;
      end
   end

   // ---------------- reference model: expected transactions ----------------
   logic [26:0] exp_q[$];
   string       tag_q[$];
   int          exp_ticks = 0;

   task automatic push(input logic w, input int a, input logic [4:0] r,
                       input logic [15:0] d, input string tag);
      exp_q.push_back({w, 5'(a), r, w ? d : 16'h0});
      tag_q.push_back(tag);
   endtask

   task automatic build(input int found, input int half, input int rst_reads, input int vanish,
                        input int an_after, input int pmax);
      int last_a;
      logic [15:0] last_ctl;
      last_a = (found < 0) ? 31 : found - 1;
      for (int a = 0; a <= last_a; a++) begin
         push(0, a, 5'd0, 0, "R1");
         push(0, a, 5'd1, 0, "R1");
      end
      if (found < 0) return;
      push(0, found, 5'd0, 0, "R1");
      push(0, found, 5'd1, 0, "R1");
      push(0, found, 5'd0, 0, "R3");
      push(1, found, 5'd0, CTL_DEF | 16'h8000, "R3");
      last_ctl = CTL_DEF;
      for (int j = 0; j < RST_MAX; j++) begin
         push(0, found, 5'd0, 0, "R4");
         if (j == vanish) return;
         if (j >= rst_reads) break;
         if (j == RST_MAX - 1) return;
      end
      push(1, found, 5'd0, last_ctl & ~16'h0400, "R6");
      push(0, found, 5'd1, 0, "R7");
      push(0, found, 5'd1, 0, "R7");
      push(1, found, 5'd4, 16'h01E1, "R8");
      push(1, found, 5'd0, 16'h1200, "R8");
      for (int p = 0; p < ((pmax < 1) ? 1 : pmax); p++) begin
         push(0, found, 5'd1, 0, "R9");
         push(0, found, 5'd1, 0, "R9");
         if (p >= an_after) begin
            push(0, found, 5'd5, 0, "R9");
            return;
         end
      end
      if (half < -1) return;
   endtask

   // per-transaction comparison at the completion cycle
   always @(negedge clk) begin
      if (rst_n && req_valid && mdio_done) begin
         if (exp_q.size() == 0) begin
            chk("R1", {5'b0, req_write, req_phy, req_reg, req_wdata}, 32'h0, "unexpected transaction");
         end else begin
            logic [26:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {5'b0, req_write, req_phy, req_reg, req_write ? req_wdata : 16'h0},
                {5'b0, e}, "transaction {wr,phy,reg,data}");
         end
      end
   end

   // R10: count ticks in each gap between negotiation polls
   bit in_gap = 0;
   int gap_ticks = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !req_valid) begin
            in_gap = 1;
            if (tick) gap_ticks++;
         end else if (in_gap) begin
            chk("R10", gap_ticks, exp_ticks, "ticks between polls");
            in_gap = 0;
            gap_ticks = 0;
         end
      end
   end

   task automatic set_dev(input int addr, input int half, input int rr, input int van,
                          input int ana, input logic [15:0] lpa);
      m_addr = addr; m_half = half; m_rst_reads = rr; m_vanish = van;
      m_an_after = ana; m_lpa = lpa; m_ctl = CTL_DEF;
      m_rst_on = 0; m_an_on = 0; m_rst_left = 0; m_poll = 0; m_sts_reads = 0;
   endtask

   task automatic run(input bool_restart);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (bool_restart) begin
         repeat (20) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R1", exp_q.size(), 0, "expected transactions left over");
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic chk_end(input string req, input logic [4:0] flags, input logic found,
                          input logic [4:0] addr, input logic [15:0] sts, input logic [15:0] lpa);
      chk(req, {an_done, err_no_phy, err_vanished, err_rst_timeout, err_an_timeout}, flags,
          "outcome {ok,nophy,gone,rst_to,an_to}");
      chk(req, phy_found, found, "phy_found");
      if (found) chk(req, phy_addr, addr, "phy_addr");
      chk(req, status_word, sts, "status_word");
      chk(req, partner_word, lpa, "partner_word");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", {busy, req_valid}, 0, "reset: busy/request");
      chk("R12", {an_done, err_no_phy, err_vanished, err_rst_timeout, err_an_timeout}, 0,
          "reset: outcome flags");

      // S1 (R1 R3 R6 R7 R9 R10 R12): device at 5, address 2 answers only control
      set_dev(5, 2, 3, -1, 2, 16'h45E1);
      cfg_poll_ticks = 8'd2; cfg_poll_max = 8'd8; exp_ticks = 2;
      build(5, 2, 3, -1, 2, 8);
      run(1);
      chk_end("R9", 5'b10000, 1, 5'd5, 16'h782D, 16'h45E1);

      // S2 (R2): nothing answers
      set_dev(-1, -1, 0, -1, 0, 16'h0);
      build(-1, -1, 0, -1, 0, 8);
      run(0);
      chk_end("R2", 5'b01000, 0, 5'd0, 16'h0, 16'h0);

      // S3 (R5 R12): device at 0 vanishes on its second reset poll
      set_dev(0, -1, 3, 1, 0, 16'h0);
      build(0, -1, 3, 1, 0, 8);
      run(0);
      chk_end("R5", 5'b00100, 1, 5'd0, 16'h0, 16'h0);

      // S4 (R4): device at 31 never leaves reset
      set_dev(31, -1, 100000, -1, 0, 16'h0);
      build(31, -1, 100000, -1, 0, 8);
      run(0);
      chk_end("R4", 5'b00010, 1, 5'd31, 16'h0, 16'h0);

      // S5 (R10): device at 7 never negotiates, three polls one tick apart
      set_dev(7, -1, 0, -1, 100000, 16'h0);
      cfg_poll_ticks = 8'd1; cfg_poll_max = 8'd3; exp_ticks = 1;
      build(7, -1, 0, -1, 100000, 3);
      run(0);
      chk_end("R10", 5'b00001, 1, 5'd7, STS_DEF, 16'h0);

      // S6 (R7 R9): immediate negotiation, five ticks configured but unused
      set_dev(1, 0, 0, -1, 0, 16'h05E1);
      cfg_poll_ticks = 8'd5; cfg_poll_max = 8'd4; exp_ticks = 5;
      build(1, 0, 0, -1, 0, 4);
      run(0);
      chk_end("R7", 5'b10000, 1, 5'd1, 16'h782D, 16'h05E1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule